// File: doc/BRIEF.md
# Modified Immediate Operand Expander

This block turns the compressed constant carried inside an immediate-form data-processing instruction into the full 32-bit second operand. It also produces the shifter carry-out that the flag-setting logic operations consume. One input selects which of two instruction encodings the word uses. In the classic encoding, an 8-bit constant is rotated right by an even amount. In the wide encoding, a 12-bit field either replicates a byte across a fixed pattern or rotates a byte whose top bit is forced to one.

The expander is purely combinational. Its outputs follow its inputs within the same cycle, so the decode stage can put it directly in front of the ALU operand mux. Alongside the operand and the carry, it reports whether a rotation was applied. Opcode decode, register reads, flag storage and condition checks all live elsewhere.

Top module: `mod_imm_expand`

## Requirements
- R1: With the classic encoding selected (wide_sel=0), the operand equals the byte in word bits [7:0], zero-extended to 32 bits and rotated right by twice the 4-bit value in word bits [11:8].
- R2: With the classic encoding and a rotate field of zero, the operand equals the byte unchanged, rot_applied is 0 and carry_out equals carry_in.
- R3: With the classic encoding and a nonzero rotate field, rot_applied is 1 and carry_out equals bit 31 of the operand.
- R4: With the wide encoding selected (wide_sel=1), a 12-bit field F is formed with F[11] = word bit 26, F[10:8] = word bits [14:12] and F[7:0] = word bits [7:0].
- R5: In the wide encoding, when F[11:10] is 00, F[9:8] selects a pattern built from the byte XY = F[7:0]: 0 gives 000000XY, 1 gives 00XY00XY, 2 gives XY00XY00 and 3 gives XYXYXYXY.
- R6: In a wide pattern mode, rot_applied is 0 and carry_out equals carry_in.
- R7: In the wide encoding, when F[11:10] is not 00, the operand is the byte {1, F[6:0]}, zero-extended and rotated right by F[11:7].
- R8: In the wide rotated mode, rot_applied is 1 and carry_out equals bit 31 of the operand.
- R9: Word bits outside [11:0] have no effect in the classic encoding, and word bits outside 26, [14:12] and [7:0] have no effect in the wide encoding.
- R10: The outputs depend only on the present inputs and change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word holding the encoded constant |
| wide_sel | input | 1 | 0 selects the classic encoding, 1 selects the wide encoding |
| carry_in | input | 1 | Current carry flag, passed through when no rotation occurs |
| operand_out | output | 32 | Expanded 32-bit immediate operand |
| carry_out | output | 1 | Shifter carry-out for flag-setting logic operations |
| rot_applied | output | 1 | High when a nonzero rotation produced the operand |

## Verification
The assertions take for granted that every input is a known 0 or 1. They also assume they are evaluated only after the combinational paths from instr_word and wide_sel have settled. For that reason, the bench changes all inputs together at one instant and samples the outputs one time step later. Random words are drawn across the full 32 bits for both encodings, so every rotate amount and every wide mode is reached. Directed words pin down the rotation of a set bit into bit 31 and the largest wide rotation.

// File: rtl/mie_pkg.sv
package mie_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CL_ROTF_W  = 4;
  localparam int unsigned WIDE_F_W   = 12;
  localparam int unsigned SHAMT_W    = $clog2(DATA_W);
  localparam int unsigned LANES      = DATA_W / BYTE_W;

  // Bit positions the instruction layout fixes.
  localparam int unsigned CL_ROT_LSB = 8;
  localparam int unsigned WD_HI_BIT  = 26;
  localparam int unsigned WD_MID_LSB = 12;

  typedef enum logic [1:0] {
    PAT_LOW  = 2'd0,
    PAT_EVEN = 2'd1,
    PAT_ODD  = 2'd2,
    PAT_ALL  = 2'd3
  } pat_mode_e;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic              rotated;
  } expand_t;
endpackage

// File: rtl/mie_classic_expand.sv
module mie_classic_expand
  import mie_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned BW   = BYTE_W,
  parameter int unsigned RFW  = CL_ROTF_W
) (
  input  logic [BW-1:0]  const_byte,
  input  logic [RFW-1:0] rot_field,
  output logic [DW-1:0]  value_out,
  output logic           rotated_out
);
  localparam int unsigned AMT_W = $clog2(DW);

  logic [AMT_W-1:0] amount;
  logic [DW-1:0]    base;
  logic [2*DW-1:0]  doubled;
  logic [2*DW-1:0]  shifted;

  always_comb begin
    amount      = AMT_W'({rot_field, 1'b0});
    base        = DW'(const_byte);
    doubled     = {base, base};
    shifted     = doubled >> amount;
    value_out   = shifted[DW-1:0];
    rotated_out = (rot_field != '0);
  end
endmodule

// File: rtl/mie_wide_expand.sv
module mie_wide_expand
  import mie_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned BW  = BYTE_W,
  parameter int unsigned FW  = WIDE_F_W
) (
  input  logic [FW-1:0] field,
  output logic [DW-1:0] value_out,
  output logic          rotated_out
);
  localparam int unsigned NLANE = DW / BW;
  localparam int unsigned AMT_W = $clog2(DW);

  logic [BW-1:0]   xy;
  pat_mode_e       mode;
  logic            is_pattern;
  logic [NLANE-1:0] lane_on;
  logic [DW-1:0]   pat_val;
  logic [DW-1:0]   rot_base;
  logic [2*DW-1:0] rot_shift;
  logic [AMT_W-1:0] amount;

  assign xy         = field[BW-1:0];
  assign mode       = pat_mode_e'(field[FW-3:FW-4]);
  assign is_pattern = (field[FW-1:FW-2] == 2'b00);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_comb begin
      unique case (mode)
        PAT_LOW:  lane_on[g] = (g == 0);
        PAT_EVEN: lane_on[g] = ((g % 2) == 0);
        PAT_ODD:  lane_on[g] = ((g % 2) == 1);
        default:  lane_on[g] = 1'b1;
      endcase
    end
    assign pat_val[g*BW +: BW] = lane_on[g] ? xy : '0;
  end

  always_comb begin
    amount    = field[FW-1:FW-1-(AMT_W-1)];
    rot_base  = DW'({1'b1, xy[BW-2:0]});
    rot_shift = {rot_base, rot_base} >> amount;
    if (is_pattern) begin
      value_out   = pat_val;
      rotated_out = 1'b0;
    end else begin
      value_out   = rot_shift[DW-1:0];
      rotated_out = 1'b1;
    end
  end
endmodule

// File: rtl/mie_carry_sel.sv
module mie_carry_sel
  import mie_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  expand_t        chosen,
  input  logic           carry_in,
  output logic [DW-1:0]  operand,
  output logic           carry_out,
  output logic           rot_applied
);
  always_comb begin
    operand     = chosen.value;
    rot_applied = chosen.rotated;
    carry_out   = chosen.rotated ? chosen.value[DW-1] : carry_in;
  end
endmodule

// File: rtl/mod_imm_expand.sv
module mod_imm_expand
  import mie_pkg::*;
(
  input  logic [DATA_W-1:0] instr_word,
  input  logic              wide_sel,
  input  logic              carry_in,
  output logic [DATA_W-1:0] operand_out,
  output logic              carry_out,
  output logic              rot_applied
);
  localparam int unsigned MID_W = WIDE_F_W - BYTE_W - 1;

  logic [DATA_W-1:0]   cl_val;
  logic                cl_rot;
  logic [DATA_W-1:0]   wd_val;
  logic                wd_rot;
  logic [WIDE_F_W-1:0] wd_field;
  expand_t             picked;
  logic                unused_bits;

  assign wd_field = {instr_word[WD_HI_BIT],
                     instr_word[WD_MID_LSB +: MID_W],
                     instr_word[BYTE_W-1:0]};

  assign unused_bits = ^{instr_word[DATA_W-1:WD_HI_BIT+1],
                         instr_word[WD_HI_BIT-1:WD_MID_LSB+MID_W]};

  mie_classic_expand #(
    .DW (DATA_W),
    .BW (BYTE_W),
    .RFW(CL_ROTF_W)
  ) u_classic (
    .const_byte (instr_word[BYTE_W-1:0]),
    .rot_field  (instr_word[CL_ROT_LSB +: CL_ROTF_W]),
    .value_out  (cl_val),
    .rotated_out(cl_rot)
  );

  mie_wide_expand #(
    .DW(DATA_W),
    .BW(BYTE_W),
    .FW(WIDE_F_W)
  ) u_wide (
    .field      (wd_field),
    .value_out  (wd_val),
    .rotated_out(wd_rot)
  );

  always_comb begin
    if (wide_sel) begin
      picked.value   = wd_val;
      picked.rotated = wd_rot;
    end else begin
      picked.value   = cl_val;
      picked.rotated = cl_rot;
    end
  end

  mie_carry_sel #(
    .DW(DATA_W)
  ) u_carry (
    .chosen     (picked),
    .carry_in   (carry_in),
    .operand    (operand_out),
    .carry_out  (carry_out),
    .rot_applied(rot_applied)
  );
endmodule

// File: rtl/mie_checker.sv
module mie_checker
  import mie_pkg::*;
(
  input logic [DATA_W-1:0] instr_word,
  input logic              wide_sel,
  input logic              carry_in,
  input logic [DATA_W-1:0] operand_out,
  input logic              carry_out,
  input logic              rot_applied
);
  logic [1:0] wide_top;
  assign wide_top = {instr_word[WD_HI_BIT], instr_word[WD_MID_LSB+2]};

  always_comb begin
    // R3, R8
    assert_rot_carry_R8: assert (!rot_applied || (carry_out == operand_out[DATA_W-1]));
    // R2, R6
    assert_pass_carry_R6: assert (rot_applied || (carry_out == carry_in));
    assert_classic_ones_R1: assert (wide_sel ||
      ($countones(operand_out) == $countones(instr_word[BYTE_W-1:0])));
    assert_classic_flat_R2: assert (wide_sel ||
      (instr_word[CL_ROT_LSB +: CL_ROTF_W] != '0) ||
      (operand_out == DATA_W'(instr_word[BYTE_W-1:0]) && !rot_applied));
    assert_classic_rot_R3: assert (wide_sel ||
      (rot_applied == (instr_word[CL_ROT_LSB +: CL_ROTF_W] != '0)));
    assert_wide_mode_R5: assert (!wide_sel || (rot_applied == (wide_top != 2'b00)));
    assert_wide_ones_R7: assert (!wide_sel || (wide_top == 2'b00) ||
      ($countones(operand_out) == $countones(instr_word[BYTE_W-2:0]) + 1));
  end
endmodule

bind mod_imm_expand mie_checker u_mie_checker (
  .instr_word (instr_word),
  .wide_sel   (wide_sel),
  .carry_in   (carry_in),
  .operand_out(operand_out),
  .carry_out  (carry_out),
  .rot_applied(rot_applied)
);

// File: tb/test_mod_imm_expand.sv
`timescale 1ns/1ps
module test_mod_imm_expand;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_word;
  logic        wide_sel;
  logic        carry_in;
  logic [31:0] operand_out;
  logic        carry_out;
  logic        rot_applied;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mod_imm_expand i_mod_imm_expand (
    .instr_word (instr_word),
    .wide_sel   (wide_sel),
    .carry_in   (carry_in),
    .operand_out(operand_out),
    .carry_out  (carry_out),
    .rot_applied(rot_applied)
  );

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  // returns {rot, carry, value}
  function automatic logic [33:0] model(input logic [31:0] w, input logic ws, input logic ci);
    logic [31:0] v;
    logic        rot;
    logic [11:0] f;
    if (!ws) begin
      v   = rotr({24'b0, w[7:0]}, 2 * int'(w[11:8]));
      rot = (w[11:8] != 4'd0);
    end else begin
      f = {w[26], w[14:12], w[7:0]};
      if (f[11:10] == 2'b00) begin
        rot = 1'b0;
        case (f[9:8])
          2'd0: v = {24'b0, f[7:0]};
          2'd1: v = {8'b0, f[7:0], 8'b0, f[7:0]};
          2'd2: v = {f[7:0], 8'b0, f[7:0], 8'b0};
          default: v = {4{f[7:0]}};
        endcase
      end else begin
        rot = 1'b1;
        v   = rotr({24'b0, 1'b1, f[6:0]}, int'(f[11:7]));
      end
    end
    return {rot, rot ? v[31] : ci, v};
  endfunction

  function automatic logic [31:0] wide_word(input logic [11:0] f, input logic [31:0] junk);
    logic [31:0] w = junk;
    w[26] = f[11];
    w[14:12] = f[10:8];
    w[7:0] = f[7:0];
    return w;
  endfunction

  task automatic apply(input logic [31:0] w, input logic ws, input logic ci);
    @(negedge clk);
    instr_word = w;
    wide_sel   = ws;
    carry_in   = ci;
    #1;
  endtask

  task automatic check_exp(input string tag, input logic [33:0] exp);
    checks++;
    if ({rot_applied, carry_out, operand_out} !== exp) begin
      failures++;
      $display("FAIL %s word=%h wide=%b cin=%b actual rot=%b c=%b op=%h expected rot=%b c=%b op=%h",
               tag, instr_word, wide_sel, carry_in, rot_applied, carry_out, operand_out,
               exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] w, input logic ws, input logic ci);
    apply(w, ws, ci);
    check_exp(tag, model(w, ws, ci));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [33:0] ref0;
    void'($urandom(32'h5EED_1234));
    instr_word = '0;
    wide_sel   = 1'b0;
    carry_in   = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // reset-state inputs: all zero word gives zero operand, no rotation
    check_exp("R2 idle", 34'h0_0000_0000);

    // R2: zero rotate field, carry passes
    run("R2 flat", 32'h0000_00FF, 1'b0, 1'b1);
    check_exp("R2 flat direct", {2'b01, 32'h0000_00FF});
    // R1/R3: bit into position 30 then 31
    run("R1 rot2", 32'h0000_0101, 1'b0, 1'b1);
    check_exp("R3 bit30", {2'b10, 32'h4000_0000});
    run("R3 bit31", 32'h0000_0102, 1'b0, 1'b0);
    check_exp("R3 bit31 direct", {2'b11, 32'h8000_0000});
    run("R1 max", 32'h0000_0FAB, 1'b0, 1'b0);

    // R4/R5/R6 patterns with XY=A5
    run("R5 p0", wide_word(12'h0A5, 32'h0), 1'b1, 1'b1);
    check_exp("R5 p0 direct", {2'b01, 32'h0000_00A5});
    run("R5 p1", wide_word(12'h1A5, 32'h0), 1'b1, 1'b0);
    check_exp("R5 p1 direct", {2'b00, 32'h00A5_00A5});
    run("R5 p2", wide_word(12'h2A5, 32'h0), 1'b1, 1'b1);
    check_exp("R6 p2 direct", {2'b01, 32'hA500_A500});
    run("R5 p3", wide_word(12'h3A5, 32'h0), 1'b1, 1'b0);
    check_exp("R6 p3 direct", {2'b00, 32'hA5A5_A5A5});
    // R7/R8 rotated
    run("R7 min", wide_word(12'h400, 32'h0), 1'b1, 1'b0);
    check_exp("R8 min direct", {2'b11, 32'h8000_0000});
    run("R7 max", wide_word(12'hFFF, 32'h0), 1'b1, 1'b1);
    check_exp("R8 max direct", {2'b10, 32'h0000_01FE});
    run("R4 hi bit", wide_word(12'h800, 32'h0), 1'b1, 1'b1);
    check_exp("R4 hi direct", {2'b10, 32'h0080_0000});

    // R9: ignored bits in both encodings
    for (int i = 0; i < 60; i++) begin
      logic [31:0] w  = $urandom;
      logic        ws = i[0];
      logic        ci = $urandom;
      logic [31:0] m  = ws ? 32'hFBFF_8F00 : 32'hFFFF_F000;
      apply(w, ws, ci);
      ref0 = {rot_applied, carry_out, operand_out};
      apply(w ^ ($urandom & m), ws, ci);
      check_exp("R9 ignored bits", ref0);
    end

    // R10: outputs follow a mid-cycle input change with no edge
    @(posedge clk);
    #2;
    instr_word = 32'h0000_0102;
    wide_sel = 1'b0;
    carry_in = 1'b0;
    #1;
    check_exp("R10 comb", {2'b11, 32'h8000_0000});

    // random, both encodings (R1 R3 R5 R7 R8)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w  = $urandom;
      logic        ci = $urandom;
      run(i[0] ? "R7 random wide" : "R1 random classic", w, i[0], ci);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule